// File: doc/BRIEF.md
# Bit shift and rotate unit

This block is the combinational data path behind the prefixed bit-manipulation instructions of an 8-bit processor. It takes an operand byte that was fetched elsewhere, an instruction class, a 3-bit selector and the current carry flag. It returns the new byte, new flag values, a per-flag update mask and a write-enable for the destination.

The class field takes the two top bits of the prefixed opcode. The selector takes the next three bits, so the decoder can wire the opcode straight in. Shift and rotate class: the selector picks the operation. Bit test, bit clear and bit set classes: the selector is the bit index. A separate `acc_form` input marks the short accumulator-only rotate opcodes. These share the rotate data path but always report a cleared zero flag.

Flags are carried as a 4-bit vector ordered {Z, N, H, C} from bit 3 down to bit 0. A flag whose update bit is 0 must be kept by the register file, and its value bit has no meaning.

Top module: `bsr_unit`

## Requirements
- R1: Class encoding: `cls` 00 is shift/rotate, 01 is bit test, 10 is bit clear, 11 is bit set. Under shift/rotate, `sel` picks the operation: 0 RLC, 1 RRC, 2 RL, 3 RR, 4 SLA, 5 SRA, 6 SWAP, 7 SRL.
- R2: RLC moves every bit up by one and copies old bit 7 into both bit 0 and C. RRC moves every bit down by one and copies old bit 0 into both bit 7 and C.
- R3: RL moves bits up and puts the incoming C into bit 0, and the new C is old bit 7. RR moves bits down and puts the incoming C into bit 7, and the new C is old bit 0.
- R4: SLA fills bit 0 with 0. SRL fills bit 7 with 0. SRA keeps bit 7. In all three, C is the bit that was shifted out, and the incoming C has no effect.
- R5: SWAP exchanges the upper and lower nibbles and returns C=0.
- R6: Every shift/rotate operation sets Z when the result is zero, returns N=0 and H=0, updates all four flags (`flg_upd`=1111) and asserts `wr_en`.
- R7: With `acc_form`=1 and `sel` 0 to 3 in the shift/rotate class, result and C are as in R2/R3 but Z is always 0. `acc_form` has no effect for `sel` 4 to 7 or for any other class.
- R8: Bit test returns Z = inverse of operand bit `sel`, N=0 and H=1. It updates Z, N and H but not C (`flg_upd`=1110), drives `wr_en`=0 and passes the operand unchanged to `res`.
- R9: Bit clear forces bit `sel` to 0 and bit set forces it to 1. Other bits are unchanged, `flg_upd`=0000 and `wr_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd | input | 8 | Operand byte |
| cls | input | 2 | Instruction class (opcode bits 7..6) |
| sel | input | 3 | Operation or bit index (opcode bits 5..3) |
| acc_form | input | 1 | Accumulator-only rotate form |
| c_in | input | 1 | Current carry flag |
| res | output | 8 | Result byte |
| flg_val | output | 4 | New flag values {Z,N,H,C} |
| flg_upd | output | 4 | Per-flag update mask {Z,N,H,C} |
| wr_en | output | 1 | Destination write-enable |

## Verification
The hardest case is an accumulator-only rotate whose result is zero. Only an all-zero operand gives it, because no rotate loses a bit, except for RL or RR with the carry bit as the only set bit shifted out and a zero carry in. The stimulus drives those exact operands in both forms and compares Z. It also sets `acc_form` with SLA, SRL and the bit classes to show the mode is ignored there. Carry-in is toggled on the non-carry shifts so that any leak of C into the result is exposed.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int DW   = 8;
  localparam int SELW = 3;
  localparam int FLW  = 4;

  typedef enum logic [1:0] {
    CLS_SHIFT = 2'b00,
    CLS_TEST  = 2'b01,
    CLS_CLEAR = 2'b10,
    CLS_SETB  = 2'b11
  } cls_e;

  typedef enum logic [SELW-1:0] {
    OP_RLC  = 3'd0,
    OP_RRC  = 3'd1,
    OP_RL   = 3'd2,
    OP_RR   = 3'd3,
    OP_SLA  = 3'd4,
    OP_SRA  = 3'd5,
    OP_SWAP = 3'd6,
    OP_SRL  = 3'd7
  } shop_e;

  // flag vector bit positions {Z,N,H,C}
  localparam int FZ = 3;
  localparam int FN = 2;
  localparam int FH = 1;
  localparam int FC = 0;
endpackage

// File: rtl/bsr_shift.sv
module bsr_shift
  import bsr_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0]    din,
  input  logic [SELW-1:0] op,
  input  logic            cin,
  output logic [W-1:0]    dout,
  output logic            cout
);
  localparam int HALF = W / 2;

  always_comb begin
    dout = din;
    cout = 1'b0;
    case (shop_e'(op))
      OP_RLC:  begin dout = {din[W-2:0], din[W-1]}; cout = din[W-1]; end
      OP_RRC:  begin dout = {din[0], din[W-1:1]};   cout = din[0];   end
      OP_RL:   begin dout = {din[W-2:0], cin};      cout = din[W-1]; end
      OP_RR:   begin dout = {cin, din[W-1:1]};      cout = din[0];   end
      OP_SLA:  begin dout = {din[W-2:0], 1'b0};     cout = din[W-1]; end
      OP_SRA:  begin dout = {din[W-1], din[W-1:1]}; cout = din[0];   end
      OP_SWAP: begin dout = {din[HALF-1:0], din[W-1:HALF]}; cout = 1'b0; end
      OP_SRL:  begin dout = {1'b0, din[W-1:1]};     cout = din[0];   end
      default: begin dout = din; cout = 1'b0; end
    endcase
  end
endmodule

// File: rtl/bsr_bitop.sv
module bsr_bitop
  import bsr_pkg::*;
#(
  parameter int W = DW,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [IW-1:0] idx,
  input  logic          force_one,
  output logic [W-1:0]  dclr_set,
  output logic          picked
);
  logic [W-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      assign hit[gi]      = (idx == IW'(gi));
      assign dclr_set[gi] = hit[gi] ? force_one : din[gi];
    end
  endgenerate

  assign picked = |(hit & din);
endmodule

// File: rtl/bsr_unit.sv
module bsr_unit
  import bsr_pkg::*;
(
  input  logic [7:0] opnd,
  input  logic [1:0] cls,
  input  logic [2:0] sel,
  input  logic       acc_form,
  input  logic       c_in,
  output logic [7:0] res,
  output logic [3:0] flg_val,
  output logic [3:0] flg_upd,
  output logic       wr_en
);
  localparam int IW = $clog2(DW);

  logic [DW-1:0] sh_res;
  logic          sh_c;
  logic [DW-1:0] bo_res;
  logic          bo_bit;
  logic          rot_only;

  bsr_shift #(.W(DW)) u_shift (
    .din  (opnd),
    .op   (sel),
    .cin  (c_in),
    .dout (sh_res),
    .cout (sh_c)
  );

  bsr_bitop #(.W(DW)) u_bitop (
    .din       (opnd),
    .idx       (sel[IW-1:0]),
    .force_one (cls == CLS_SETB),
    .dclr_set  (bo_res),
    .picked    (bo_bit)
  );

  // accumulator forms exist only for the four rotate selectors
  assign rot_only = acc_form && (sel[2] == 1'b0);

  always_comb begin
    res     = opnd;
    flg_val = '0;
    flg_upd = '0;
    wr_en   = 1'b0;
    case (cls_e'(cls))
      CLS_SHIFT: begin
        res         = sh_res;
        flg_val[FZ] = rot_only ? 1'b0 : (sh_res == '0);
        flg_val[FC] = sh_c;
        flg_upd     = 4'b1111;
        wr_en       = 1'b1;
      end
      CLS_TEST: begin
        flg_val[FZ] = ~bo_bit;
        flg_val[FH] = 1'b1;
        flg_val[FC] = c_in;
        flg_upd     = 4'b1110;
      end
      default: begin
        res   = bo_res;
        wr_en = 1'b1;
      end
    endcase
  end

  // checks against the sub-block outputs
  always_comb begin
    if (!$isunknown({opnd, cls, sel, acc_form, c_in})) begin
      if (cls == CLS_TEST)
        a_r8_test_no_write : assert (!wr_en && flg_upd == 4'b1110 && res == opnd);
      if (cls[1])
        a_r9_bitop_no_flags : assert (flg_upd == 4'b0000 && wr_en);
      if (cls == CLS_CLEAR)
        a_r9_clear_bit : assert (res[sel] == 1'b0);
      if (cls == CLS_SETB)
        a_r9_set_bit : assert (res[sel] == 1'b1);
      if (cls == CLS_SHIFT)
        a_r6_shift_nh_clear : assert (!flg_val[FN] && !flg_val[FH] && wr_en);
      if (cls == CLS_SHIFT && acc_form && !sel[2])
        a_r7_acc_zero_low : assert (!flg_val[FZ]);
      if (cls == CLS_SHIFT && sel == 3'd6)
        a_r5_swap_carry : assert (!flg_val[FC] && $countones(res) == $countones(opnd));
    end
  end
endmodule

// File: tb/bsr_unit_tb.sv
`timescale 1ns/1ps
module bsr_unit_tb;
  logic       clk;
  logic [7:0] opnd;
  logic [1:0] cls;
  logic [2:0] sel;
  logic       acc_form;
  logic       c_in;
  logic [7:0] res;
  logic [3:0] flg_val;
  logic [3:0] flg_upd;
  logic       wr_en;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic [7:0] r;
    logic [3:0] f;
    logic [3:0] u;
    logic       we;
    string      tag;
  } exp_t;

  exp_t sb[$];

  bsr_unit u_dut (
    .opnd(opnd), .cls(cls), .sel(sel), .acc_form(acc_form), .c_in(c_in),
    .res(res), .flg_val(flg_val), .flg_upd(flg_upd), .wr_en(wr_en)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // independent reference built bit by bit
  function automatic exp_t model(logic [7:0] v, logic [1:0] k, logic [2:0] s,
                                 logic af, logic ci, string tag);
    exp_t e;
    logic [7:0] r;
    logic c;
    r = v; c = 0;
    e.tag = tag;
    if (k == 2'b00) begin
      for (int i = 0; i < 8; i++) begin
        case (s)
          3'd0: r[i] = v[(i + 7) % 8];
          3'd1: r[i] = v[(i + 1) % 8];
          3'd2: r[i] = (i == 0) ? ci : v[i-1];
          3'd3: r[i] = (i == 7) ? ci : v[i+1];
          3'd4: r[i] = (i == 0) ? 1'b0 : v[i-1];
          3'd5: r[i] = (i == 7) ? v[7] : v[i+1];
          3'd6: r[i] = v[(i + 4) % 8];
          default: r[i] = (i == 7) ? 1'b0 : v[i+1];
        endcase
      end
      if (s == 3'd0 || s == 3'd2 || s == 3'd4) c = v[7];
      else if (s == 3'd6) c = 0;
      else c = v[0];
      e.r = r;
      e.f = {(af && s < 4) ? 1'b0 : (r == 8'h00), 1'b0, 1'b0, c};
      e.u = 4'hF; e.we = 1;
    end else if (k == 2'b01) begin
      e.r = v; e.f = {~v[s], 1'b0, 1'b1, 1'b0}; e.u = 4'hE; e.we = 0;
    end else begin
      r[s] = (k == 2'b11);
      e.r = r; e.f = 4'h0; e.u = 4'h0; e.we = 1;
    end
    return e;
  endfunction

  task automatic drive(logic [7:0] v, logic [1:0] k, logic [2:0] s,
                       logic af, logic ci, string tag);
    @(negedge clk);
    opnd = v; cls = k; sel = s; acc_form = af; c_in = ci;
    sb.push_back(model(v, k, s, af, ci, tag));
  endtask

  // monitor: compares one queued item per cycle, away from the edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (res !== e.r || (flg_val & e.u) !== (e.f & e.u) ||
          flg_upd !== e.u || wr_en !== e.we) begin
        bad++;
        $display("FAIL %s: got res=%h f=%b u=%b we=%b exp res=%h f=%b u=%b we=%b",
                 e.tag, res, flg_val & e.u, flg_upd, wr_en,
                 e.r, e.f & e.u, e.u, e.we);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang exp finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    opnd = 0; cls = 0; sel = 0; acc_form = 0; c_in = 0;
    drive(8'h00, 2'b00, 3'd0, 0, 0, "R6 idle zero");
    // R1/R2 circular rotates
    drive(8'h85, 2'b00, 3'd0, 0, 0, "R2 rlc");
    drive(8'h01, 2'b00, 3'd1, 0, 0, "R2 rrc");
    drive(8'h80, 2'b00, 3'd1, 0, 1, "R2 rrc ci");
    // R3 through carry
    drive(8'h80, 2'b00, 3'd2, 0, 0, "R3 rl to zero");
    drive(8'h40, 2'b00, 3'd2, 0, 1, "R3 rl ci");
    drive(8'h01, 2'b00, 3'd3, 0, 0, "R3 rr to zero");
    drive(8'h02, 2'b00, 3'd3, 0, 1, "R3 rr ci");
    // R4 shifts with carry-in toggled
    for (int ci = 0; ci < 2; ci++) begin
      drive(8'h81, 2'b00, 3'd4, 0, ci[0], "R4 sla");
      drive(8'h81, 2'b00, 3'd5, 0, ci[0], "R4 sra");
      drive(8'h81, 2'b00, 3'd7, 0, ci[0], "R4 srl");
    end
    drive(8'h80, 2'b00, 3'd4, 0, 1, "R4 sla zero");
    drive(8'h01, 2'b00, 3'd7, 0, 0, "R4 srl zero");
    // R5 swap
    drive(8'hA5, 2'b00, 3'd6, 0, 1, "R5 swap");
    drive(8'h00, 2'b00, 3'd6, 0, 1, "R5 swap zero");
    // R7 accumulator forms
    drive(8'h00, 2'b00, 3'd0, 1, 0, "R7 acc rlc zero");
    drive(8'h00, 2'b00, 3'd1, 1, 0, "R7 acc rrc zero");
    drive(8'h80, 2'b00, 3'd2, 1, 0, "R7 acc rl zero");
    drive(8'h01, 2'b00, 3'd3, 1, 0, "R7 acc rr zero");
    drive(8'h81, 2'b00, 3'd0, 1, 1, "R7 acc rlc data");
    drive(8'h80, 2'b00, 3'd4, 1, 0, "R7 acc ignored sla");
    drive(8'h01, 2'b00, 3'd7, 1, 0, "R7 acc ignored srl");
    drive(8'h00, 2'b01, 3'd2, 1, 0, "R7 acc ignored test");
    // R8 bit test over every index
    for (int i = 0; i < 8; i++) begin
      drive(8'h5A, 2'b01, 3'(i), 0, i[0], "R8 test");
    end
    // R9 clear and set
    for (int i = 0; i < 8; i++) begin
      drive(8'hFF, 2'b10, 3'(i), 0, 1, "R9 clear");
      drive(8'h00, 2'b11, 3'(i), 0, 1, "R9 set");
    end
    drive(8'h3C, 2'b10, 3'd0, 0, 0, "R9 clear already zero");
    drive(8'h3C, 2'b11, 3'd2, 1, 0, "R9 set already one");
    // R1 all class/selector combinations on one operand
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 8; s++) begin
        drive(8'hC3, 2'(k), 3'(s), 0, 1, "R1 sweep");
      end
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule